// File: doc/BRIEF.md
# Pulse-Width Encoder for Chained RGB LEDs

This block turns a stream of colour bytes into the single-wire waveform understood by chains of addressable RGB LEDs. Bytes arrive over a byte-wide ready/valid handshake, three per LED. Each bit goes out as a bit cell of fixed length. The cell always starts high, and the falling edge comes early for a zero and late for a one. No clock is sent, so the receiving LED recovers each bit from the pulse width alone.

A frame is a run of bytes with no gap between them. One byte waits in a holding slot while the current byte is shifted out, so a source that keeps up keeps the line busy. A frame ends when the last bit cell of a byte finishes and no further byte has been accepted. The line is then held low for a long latch interval so the LEDs show the new colours. After that the block raises a one-cycle frame-done strobe and becomes ready for the next frame.

Top module: `led_encoder`

## Requirements
- R1: In reset and just after it, `led_out` is 0, `frame_done` is 0 and `in_ready` is 1.
- R2: Every bit cell lasts exactly CELL_CLKS clocks (20 by default), whether the bit is a zero or a one.
- R3: A zero bit drives `led_out` high for exactly ZERO_HI clocks (6 by default) at the start of its cell, then low for the rest of the cell.
- R4: A one bit drives `led_out` high for exactly ONE_HI clocks (13 by default) at the start of its cell, then low for the rest of the cell.
- R5: Within a byte, bit 7 is sent first and bit 0 last. Bytes are sent in the order they were accepted.
- R6: Within a frame, consecutive rising edges of `led_out` are exactly CELL_CLKS clocks apart, including across byte boundaries.
- R7: A frame ends when the last cell of a byte finishes and no next byte was accepted by the edge that closes that cell. The line then stays low for LATCH_CLKS clocks (800 by default), and `frame_done` is high in the cycle that is CELL_CLKS+LATCH_CLKS clocks after the last rising edge.
- R8: `frame_done` is high for exactly one cycle per frame.
- R9: `in_ready` is 0 from the end of a frame until `frame_done` has been high. A byte offered during that interval is accepted only after the strobe, and it starts a new frame.
- R10: While a byte is being sent, one more byte can be accepted. `in_ready` is 0 while that holding slot is occupied.
- R11: `led_out` stays low while idle. No pulse appears unless a byte has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Colour byte offered by the source |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Block takes `in_data` on this edge if `in_valid` is high |
| led_out | output | 1 | Single-wire pulse-width data line |
| frame_done | output | 1 | One-cycle strobe after the latch interval |

## Verification
The first rising edge of `led_out` is seen in the cycle right after the edge that accepts the first byte. The falling edge follows ZERO_HI or ONE_HI cycles later, and the next rising edge comes CELL_CLKS cycles after the previous one. `frame_done` appears exactly CELL_CLKS+LATCH_CLKS cycles after the final rising edge. The monitor samples on the falling clock edge and counts cycles from each rising edge, so every width, spacing and latch length is checked against an exact count rather than a window. Bytes rebuilt from the measured pulse widths are compared in order against a queue that the driver fills at the moment each byte is accepted.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_LATCH = 2'd2,
        ST_DONE  = 2'd3
    } enc_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              full;
    } byte_slot_t;

    // high-phase length of a cell for the given bit value
    function automatic int unsigned hi_clks(input logic bit_val,
                                            input int unsigned zero_hi,
                                            input int unsigned one_hi);
        return bit_val ? one_hi : zero_hi;
    endfunction

endpackage

// File: rtl/led_cell_timer.sv
module led_cell_timer
    import led_enc_pkg::*;
#(
    parameter int unsigned CELL_CLKS = 20,
    parameter int unsigned ZERO_HI   = 6,
    parameter int unsigned ONE_HI    = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic bit_val,
    output logic cell_end,
    output logic line_hi
);
    localparam int unsigned CNT_W = $clog2(CELL_CLKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CELL_CLKS - 1);
    localparam logic [CNT_W-1:0] ZERO_LEN = CNT_W'(ZERO_HI);
    localparam logic [CNT_W-1:0] ONE_LEN  = CNT_W'(ONE_HI);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hi_len;

    always_comb begin
        hi_len = CNT_W'(hi_clks(bit_val, int'(ZERO_LEN), int'(ONE_LEN)));
    end

    assign cell_end = run && (cnt_q == CNT_LAST);
    assign line_hi  = run && (cnt_q < hi_len);

    always_ff @(posedge clk) begin
        if (rst || !run || cell_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/led_bit_shifter.sv
module led_bit_shifter
    import led_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_first,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              cell_end,
    output logic              cur_bit,
    output logic              last_bit,
    output logic              slot_full,
    output logic              more_data
);
    localparam int unsigned IDX_W = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shift_q;
    logic [IDX_W-1:0]  idx_q;
    byte_slot_t        slot_q;

    assign cur_bit   = shift_q[BYTE_W-1];
    assign last_bit  = (idx_q == '0);
    assign slot_full = slot_q.full;
    // a byte is available to follow the current one
    assign more_data = slot_q.full || push;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            idx_q   <= '0;
            slot_q  <= '{data: '0, full: 1'b0};
        end else if (load_first) begin
            shift_q <= push_data;
            idx_q   <= IDX_TOP;
        end else begin
            if (cell_end && !last_bit) begin
                shift_q <= shift_q << 1;
                idx_q   <= idx_q - 1'b1;
            end else if (cell_end && slot_q.full) begin
                shift_q     <= slot_q.data;
                idx_q       <= IDX_TOP;
                slot_q.full <= 1'b0;
            end else if (cell_end && push) begin
                // byte arrives in the very cycle the slot would be read
                shift_q <= push_data;
                idx_q   <= IDX_TOP;
            end
            if (push && !(cell_end && last_bit)) begin
                slot_q <= '{data: push_data, full: 1'b1};
            end
        end
    end
endmodule

// File: rtl/led_frame_ctrl.sv
module led_frame_ctrl
    import led_enc_pkg::*;
#(
    parameter int unsigned LATCH_CLKS = 800
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       frame_end,
    output enc_state_t state
);
    localparam int unsigned LAT_W = $clog2(LATCH_CLKS);
    localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(LATCH_CLKS - 1);

    enc_state_t       state_q;
    logic [LAT_W-1:0] lat_q;

    assign state = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lat_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) state_q <= ST_SEND;
                ST_SEND: if (frame_end) begin
                    state_q <= ST_LATCH;
                    lat_q   <= '0;
                end
                ST_LATCH: begin
                    if (lat_q == LAT_LAST) state_q <= ST_DONE;
                    else                   lat_q   <= lat_q + 1'b1;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/led_encoder.sv
module led_encoder
    import led_enc_pkg::*;
#(
    parameter int unsigned CELL_CLKS  = 20,
    parameter int unsigned ZERO_HI    = 6,
    parameter int unsigned ONE_HI     = 13,
    parameter int unsigned LATCH_CLKS = 800
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic       led_out,
    output logic       frame_done
);
    enc_state_t state;
    logic       sending, accept, load_first, push;
    logic       cell_end, line_hi, cur_bit, last_bit, slot_full, more_data;
    logic       frame_end;

    assign sending    = (state == ST_SEND);
    assign in_ready   = (state == ST_IDLE) || (sending && !slot_full);
    assign accept     = in_valid && in_ready;
    assign load_first = accept && (state == ST_IDLE);
    assign push       = accept && sending;
    assign frame_end  = cell_end && last_bit && !more_data;
    assign led_out    = line_hi;
    assign frame_done = (state == ST_DONE);

    led_frame_ctrl #(.LATCH_CLKS(LATCH_CLKS)) u_ctrl (
        .clk(clk), .rst(rst), .start(load_first),
        .frame_end(frame_end), .state(state)
    );

    led_cell_timer #(.CELL_CLKS(CELL_CLKS), .ZERO_HI(ZERO_HI), .ONE_HI(ONE_HI)) u_timer (
        .clk(clk), .rst(rst), .run(sending), .bit_val(cur_bit),
        .cell_end(cell_end), .line_hi(line_hi)
    );

    led_bit_shifter u_shift (
        .clk(clk), .rst(rst), .load_first(load_first), .push(push),
        .push_data(in_data), .cell_end(cell_end), .cur_bit(cur_bit),
        .last_bit(last_bit), .slot_full(slot_full), .more_data(more_data)
    );
endmodule

// File: rtl/led_encoder_chk.sv
module led_encoder_chk #(
    parameter int unsigned CELL_CLKS  = 20,
    parameter int unsigned ZERO_HI    = 6,
    parameter int unsigned ONE_HI     = 13,
    parameter int unsigned LATCH_CLKS = 800
) (
    input logic clk,
    input logic rst,
    input logic led_out,
    input logic in_ready,
    input logic frame_done
);
    localparam int unsigned GAP   = CELL_CLKS + LATCH_CLKS;
    localparam int unsigned SW    = $clog2(GAP + 2) + 1;
    localparam logic [SW-1:0] SMAX = '1;

    logic [SW-1:0] hi_len, since_rise;
    logic          in_frame, led_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len     <= '0;
            since_rise <= '0;
            in_frame   <= 1'b0;
            led_d      <= 1'b0;
        end else begin
            led_d  <= led_out;
            hi_len <= led_out ? hi_len + 1'b1 : '0;
            if (led_out && !led_d)       since_rise <= SW'(1);
            else if (since_rise != SMAX) since_rise <= since_rise + 1'b1;
            if (led_out && !led_d)       in_frame <= 1'b1;
            else if (frame_done)         in_frame <= 1'b0;
        end
    end

    // R3 / R4: every high pulse has one of the two legal widths
    assert_pulse_width_R3_R4: assert property (@(posedge clk) disable iff (rst)
        (!led_out && led_d) |-> (hi_len == SW'(ZERO_HI) || hi_len == SW'(ONE_HI)));

    // R6: rising edges within a frame are one cell apart
    assert_cell_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        (led_out && !led_d && in_frame) |-> (since_rise == SW'(CELL_CLKS)));

    // R7: strobe lands one cell plus the latch gap after the last rise
    assert_latch_gap_R7: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (since_rise == SW'(GAP)));

    // R8: strobe lasts one cycle
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R9: no acceptance while the strobe is up
    assert_no_accept_done_R9: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !in_ready);

    // R11: line is low while the frame is closing
    assert_line_low_done_R11: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !led_out);
endmodule

bind led_encoder led_encoder_chk #(
    .CELL_CLKS(CELL_CLKS), .ZERO_HI(ZERO_HI), .ONE_HI(ONE_HI), .LATCH_CLKS(LATCH_CLKS)
) u_chk (
    .clk(clk), .rst(rst), .led_out(led_out),
    .in_ready(in_ready), .frame_done(frame_done)
);

// File: tb/tb_led_encoder.sv
`timescale 1ns/1ps
module tb_led_encoder;
    localparam int CELL  = 20;
    localparam int ZH    = 6;
    localparam int OH    = 13;
    localparam int LATCH = 800;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready, led_out, frame_done;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    led_encoder dut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .led_out(led_out), .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(1'b0, "watchdog", cycles, 100000);
            finish_run();
        end
    end

    // ---------------- monitor ----------------
    logic       prev_led = 1'b0, prev_done = 1'b0, in_frame = 1'b0;
    int         hi_cnt = 0, since = 0, nbits = 0, frames = 0;
    logic [7:0] rx = '0;

    always @(negedge clk) begin
        if (!rst) begin
            since++;
            if (led_out && !prev_led) begin
                if (in_frame) check(since == CELL, "R6 R2 rise spacing", since, CELL);
                if (nbits == 0)
                    check(exp_q.size() != 0, "R11 pulse without accepted byte", 0, 1);
                in_frame = 1'b1;
                since = 0;
            end
            if (led_out) hi_cnt++;
            if (!led_out && prev_led) begin
                check(hi_cnt == ZH || hi_cnt == OH, "R3 R4 high width", hi_cnt, ZH);
                rx = {rx[6:0], (hi_cnt == OH)};
                nbits++;
                hi_cnt = 0;
                if (nbits == 8) begin
                    nbits = 0;
                    if (exp_q.size() == 0) check(1'b0, "R5 unexpected byte", rx, -1);
                    else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        check(rx == e, "R5 byte order", rx, e);
                    end
                end
            end
            if (frame_done) begin
                check(since == CELL + LATCH, "R7 latch gap", since, CELL + LATCH);
                check(!led_out && !in_ready, "R9 done state", {led_out, in_ready}, 0);
                in_frame = 1'b0;
                frames++;
            end
            if (prev_done) check(!frame_done, "R8 strobe width", frame_done, 0);
            prev_led  = led_out;
            prev_done = frame_done;
        end
    end

    // ---------------- driver ----------------
    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);          // accepted at the edge in between
        exp_q.push_back(b);
        in_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!frame_done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(led_out == 1'b0, "R1 led after reset", led_out, 0);
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        check(frame_done == 1'b0, "R1 done after reset", frame_done, 0);
        repeat (40) @(negedge clk);
        check(led_out == 1'b0, "R11 idle line", led_out, 0);

        // one LED: all zeros, all ones, mixed
        send_byte(8'h00);
        send_byte(8'hFF);
        send_byte(8'hA5);
        wait_done();

        // two LEDs; R10 slot full right after second accept
        send_byte(8'h01);
        send_byte(8'h80);
        check(in_ready == 1'b0, "R10 ready low with slot full", in_ready, 0);
        send_byte(8'h3C);
        send_byte(8'hC3);
        send_byte(8'h5A);
        send_byte(8'h7E);
        wait_done();

        // R7/R9: source stalls, frame closes, late byte waits for strobe
        send_byte(8'h96);
        repeat (8 * CELL + 20) @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h69;
        begin
            bit seen_done = 1'b0;
            bit early     = 1'b0;
            while (!in_ready) begin
                if (frame_done) seen_done = 1'b1;
                @(negedge clk);
            end
            if (!seen_done && !prev_done) early = 1'b1;
            check(!early, "R9 byte held until strobe", early, 0);
        end
        @(negedge clk);
        exp_q.push_back(8'h69);
        in_valid = 1'b0;
        wait_done();

        repeat (20) @(negedge clk);
        check(frames == 4, "R7 frame count", frames, 4);
        check(exp_q.size() == 0, "R5 all bytes sent", exp_q.size(), 0);
        check(led_out == 1'b0, "R11 idle after frames", led_out, 0);
        finish_run();
    end
endmodule